// File: doc/BRIEF.md
# Pipelined Matrix Multiply Engine

This engine multiplies two square matrices of signed 32-bit integers and writes the product matrix. All three matrices live in external synchronous single-port memories. A single start pulse launches one operation. The engine flattens the row, column and inner-product loops into one sequence of DIM^3 steps (4096 with the default DIM of 16). It issues one multiply-accumulate per clock, so the operand memories are read on every cycle of the run.

Each step reads one element of A and one element of B. Two pipeline stages later, the step's product has been folded into an accumulator register. The accumulator restarts at the first inner step of each output element. After the last inner step of an element, the engine writes the element to the C memory. Status outputs let a controller hand over a new job: ready and idle show that the engine is waiting, and done marks the end of a job.

Top module: `mat_mult_engine`

## Requirements
- R1: After reset, idle and ready are 1. Done, a_ce, b_ce, c_ce and c_we are all 0.
- R2: When start is 1 at a clock edge while idle is 1, the engine begins on the next cycle. In that cycle a_ce and b_ce are 1, both read addresses are 0, and idle and ready are 0.
- R3: Element (r,c) sits at address r*16+c. Run cycles are numbered from 1 (the first cycle after start is accepted). Read cycle n+1 performs step n, for n = 0..4095. Step n uses row i=n/256, column j=(n/16)%16 and inner index k=n%16, with a_addr=i*16+k and b_addr=k*16+j. a_ce and b_ce are 1 on exactly these 4096 consecutive cycles and 0 otherwise.
- R4: Read data is taken from a_rdata and b_rdata in the cycle after the cycle in which the address was presented with its chip enable.
- R5: Each product element C(i,j) is written exactly once. The write takes one cycle with c_ce=1, c_we=1 and c_addr=i*16+j, three cycles after the read cycle of its k=15 step. Elements are written in row-major order, 256 writes per job, and c_we is never 1 without c_ce.
- R6: Multiplication and accumulation use two's complement arithmetic and keep the low 32 bits of every product and sum.
- R7: Done is 1 for exactly one cycle: the cycle after the final write (run cycle 4100). In that same cycle idle and ready return to 1. Between the start edge and that cycle, idle and ready are 0.
- R8: A start pulse while a job is running or draining has no effect on the addresses, the written data or the timing.
- R9: Each output element's sum starts from its own k=0 product. No part of the previous element's sum is carried into it.
- R10: A start given in the done cycle is accepted, and the next job's first read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job (sampled while idle) |
| done | output | 1 | One-cycle pulse after the final write |
| idle | output | 1 | No job in progress |
| ready | output | 1 | A start would be accepted |
| a_addr | output | 8 | Matrix A read address |
| a_ce | output | 1 | Matrix A read enable |
| a_rdata | input | 32 | Matrix A read data (one cycle after enable) |
| b_addr | output | 8 | Matrix B read address |
| b_ce | output | 1 | Matrix B read enable |
| b_rdata | input | 32 | Matrix B read data (one cycle after enable) |
| c_addr | output | 8 | Matrix C write address |
| c_ce | output | 1 | Matrix C enable |
| c_we | output | 1 | Matrix C write enable |
| c_wdata | output | 32 | Matrix C write data |

## Verification
The bench targets the following corner cases and the failure each would expose:

- **Element seams.** An accumulator that missed its clear would bleed one element's sum into the next, so the bench uses data with a large nonzero sum in every element.
- **Pipeline timing.** A write issued one cycle early or late, or a read-latency mismatch, would shift every element by one product term.
- **Wraparound.** Operands near the top of the signed range push products and sums past 32 bits, so a design that saturates or widens wrongly writes bad values.
- **Start handling.** Start pulses are injected mid-run and during the drain, where a design that restarts would scramble addresses. A job is also chained from the done cycle, where a design that ignores that start loses a cycle or the whole job.

// File: rtl/mm_pkg.sv
package mm_pkg;

   typedef enum logic [1:0] {
      MM_WAIT  = 2'd0,
      MM_FEED  = 2'd1,
      MM_FLUSH = 2'd2
   } mm_phase_e;

endpackage

// File: rtl/mm_step_counter.sv
module mm_step_counter #(
   parameter int DIM   = 16,
   parameter int IDX_W = $clog2(DIM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] row,
   output logic [IDX_W-1:0] col,
   output logic [IDX_W-1:0] inner,
   output logic             first_term,
   output logic             last_term,
   output logic             last_step
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(DIM - 1);

   logic inner_wrap, col_wrap;

   assign inner_wrap = (inner == TOP);
   assign col_wrap   = (col == TOP);
   assign first_term = (inner == '0);
   assign last_term  = inner_wrap;
   assign last_step  = inner_wrap && col_wrap && (row == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         row   <= '0;
         col   <= '0;
         inner <= '0;
      end else if (advance) begin
         inner <= inner_wrap ? '0 : inner + 1'b1;
         if (inner_wrap) begin
            col <= col_wrap ? '0 : col + 1'b1;
            if (col_wrap)
               row <= (row == TOP) ? '0 : row + 1'b1;
         end
      end
   end

   AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && !inner_wrap) |=> (inner == $past(inner) + 1'b1)) // R3
      else $error("inner index did not advance by one");

endmodule

// File: rtl/mm_mac_pipe.sv
module mm_mac_pipe #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter bit REG_PRODUCT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              issue_first,
   input  logic              issue_last,
   input  logic              issue_final,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [DATA_W-1:0] a_rdata,
   input  logic [DATA_W-1:0] b_rdata,
   output logic              wr_en,
   output logic              wr_final,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   // stage 1: operands arrive from memory
   logic              v1, f1, l1, z1;
   logic [ADDR_W-1:0] ad1;
   logic [DATA_W-1:0] prod_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0; z1 <= 1'b0; ad1 <= '0;
      end else begin
         v1 <= issue;
         f1 <= issue_first;
         l1 <= issue_last;
         z1 <= issue_final;
         ad1 <= issue_addr;
      end
   end

   assign prod_raw = a_rdata * b_rdata;

   // stage 2: optional product register
   logic              v2, f2, l2, z2;
   logic [ADDR_W-1:0] ad2;
   logic [DATA_W-1:0] prod;

   generate
      if (REG_PRODUCT) begin : g_prod_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0; z2 <= 1'b0;
               ad2 <= '0; prod <= '0;
            end else begin
               v2 <= v1; f2 <= f1; l2 <= l1; z2 <= z1;
               ad2 <= ad1; prod <= prod_raw;
            end
         end
      end else begin : g_prod_comb
         assign v2 = v1;
         assign f2 = f1;
         assign l2 = l1;
         assign z2 = z1;
         assign ad2 = ad1;
         assign prod = prod_raw;
      end
   endgenerate

   // stage 3: accumulate
   logic              v3, l3, z3;
   logic [ADDR_W-1:0] ad3;
   logic [DATA_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v3 <= 1'b0; l3 <= 1'b0; z3 <= 1'b0; ad3 <= '0; acc <= '0;
      end else begin
         v3 <= v2;
         l3 <= l2;
         z3 <= z2;
         ad3 <= ad2;
         if (v2)
            acc <= f2 ? prod : acc + prod;
      end
   end

   assign wr_en    = v3 && l3;
   assign wr_final = v3 && z3;
   assign wr_addr  = ad3;
   assign wr_data  = acc;

   AST_FINAL_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_final |-> wr_en) // R5
      else $error("final step without a write");

endmodule

// File: rtl/mat_mult_engine.sv
module mat_mult_engine #(
   parameter int DIM         = 16,
   parameter int DATA_W      = 32,
   parameter bit REG_PRODUCT = 1'b1,
   parameter int IDX_W       = $clog2(DIM),
   parameter int ADDR_W      = 2 * IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              idle,
   output logic              ready,
   output logic [ADDR_W-1:0] a_addr,
   output logic              a_ce,
   input  logic [DATA_W-1:0] a_rdata,
   output logic [ADDR_W-1:0] b_addr,
   output logic              b_ce,
   input  logic [DATA_W-1:0] b_rdata,
   output logic [ADDR_W-1:0] c_addr,
   output logic              c_ce,
   output logic              c_we,
   output logic [DATA_W-1:0] c_wdata
);
   import mm_pkg::*;

   generate
      if (DIM < 2 || (DIM & (DIM - 1)) != 0) begin : g_bad_dim
         $error("DIM must be a power of two and at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W != 2 * IDX_W) begin : g_bad_addr
         $error("ADDR_W must equal twice the index width");
      end
   endgenerate

   mm_phase_e         phase;
   logic              done_q;
   logic              accept, feeding;
   logic [IDX_W-1:0]  row, col, inner;
   logic              first_term, last_term, last_step;
   logic              wr_en, wr_final;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   assign accept  = (phase == MM_WAIT) && start;
   assign feeding = (phase == MM_FEED);

   mm_step_counter #(.DIM(DIM), .IDX_W(IDX_W)) u_steps (
      .clk(clk), .rst_n(rst_n), .clear(accept), .advance(feeding),
      .row(row), .col(col), .inner(inner),
      .first_term(first_term), .last_term(last_term), .last_step(last_step)
   );

   mm_mac_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_PRODUCT(REG_PRODUCT)) u_mac (
      .clk(clk), .rst_n(rst_n),
      .issue(feeding), .issue_first(first_term), .issue_last(last_term),
      .issue_final(feeding && last_step), .issue_addr({row, col}),
      .a_rdata(a_rdata), .b_rdata(b_rdata),
      .wr_en(wr_en), .wr_final(wr_final), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= MM_WAIT;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase)
            MM_WAIT:  if (start) phase <= MM_FEED;
            MM_FEED:  if (last_step) phase <= MM_FLUSH;
            MM_FLUSH: if (wr_final) begin
               phase  <= MM_WAIT;
               done_q <= 1'b1;
            end
            default:  phase <= MM_WAIT;
         endcase
      end
   end

   assign idle    = (phase == MM_WAIT);
   assign ready   = idle;
   assign done    = done_q;
   assign a_ce    = feeding;
   assign b_ce    = feeding;
   assign a_addr  = {row, inner};
   assign b_addr  = {inner, col};
   assign c_ce    = wr_en;
   assign c_we    = wr_en;
   assign c_addr  = wr_addr;
   assign c_wdata = wr_data;

   AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      c_we |-> c_ce) // R5
      else $error("write enable without chip enable");

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) // R7
      else $error("done held longer than one cycle");

   AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (idle && ready)) // R7
      else $error("done without idle and ready");

   AST_NO_FETCH_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!a_ce && !b_ce)) // R3
      else $error("operand read while idle");

   AST_FETCH_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_ce) |-> $past(start)) // R2
      else $error("job began without start");

endmodule

// File: tb/mat_mult_engine_test.sv
`timescale 1ns/1ps
module mat_mult_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        done, idle, ready;
   logic [7:0]  a_addr, b_addr, c_addr;
   logic        a_ce, b_ce, c_ce, c_we;
   logic [31:0] a_rdata = '0, b_rdata = '0, c_wdata;

   logic [31:0] ma [256];
   logic [31:0] mb [256];
   logic [31:0] mc [256];

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mat_mult_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .done(done), .idle(idle), .ready(ready),
      .a_addr(a_addr), .a_ce(a_ce), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_ce(b_ce), .b_rdata(b_rdata),
      .c_addr(c_addr), .c_ce(c_ce), .c_we(c_we), .c_wdata(c_wdata)
   );

   // memory models: data one cycle after enable (R4)
   always @(posedge clk) begin
      if (a_ce) a_rdata <= ma[a_addr];
      if (b_ce) b_rdata <= mb[b_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int kind);
      logic [31:0] seed = 32'h1234_5678;
      for (int x = 0; x < 256; x++) begin
         case (kind)
            0: begin ma[x] = 32'(x % 7 + 1); mb[x] = 32'(x % 5) - 32'd2; end
            1: begin ma[x] = 32'h7fff_fff0 + 32'(x); mb[x] = 32'h0001_0003 * 32'(x + 1); end
            default: begin
               seed = seed * 32'd1664525 + 32'd1013904223;
               ma[x] = seed;
               seed = seed * 32'd1664525 + 32'd1013904223;
               mb[x] = seed;
            end
         endcase
      end
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++) begin
            logic [31:0] s = '0;
            for (int k = 0; k < 16; k++) s = s + ma[i*16+k] * mb[k*16+j];
            mc[i*16+j] = s;
         end
   endtask

   // one job, checked every cycle; cycle 1 = first cycle after start accepted
   task automatic run_job(input bit chained, input bit poke, input bit chain_next,
                          input int next_kind, input string dtag);
      if (!chained) begin
         start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
      for (int cyc = 1; cyc <= 4100; cyc++) begin
         bit    exp_ce  = (cyc >= 1 && cyc <= 4096);
         int    m       = cyc - 4;
         bit    exp_wr  = (m >= 0 && m <= 4095 && (m % 16) == 15);
         bit    exp_end = (cyc == 4100);
         string ctag    = (cyc == 1) ? (chained ? "R10" : "R2") : "R3";
         string stag    = (cyc == 1) ? "R2" : ((poke && cyc > 100) ? "R8" : "R7");
         chk(a_ce === exp_ce, ctag, "a_ce", 32'(a_ce), 32'(exp_ce));
         chk(b_ce === exp_ce, ctag, "b_ce", 32'(b_ce), 32'(exp_ce));
         if (exp_ce) begin
            int n = cyc - 1;
            int i = n / 256, j = (n / 16) % 16, k = n % 16;
            chk(a_addr === 8'(i*16+k), ctag, "a_addr", 32'(a_addr), 32'(i*16+k));
            chk(b_addr === 8'(k*16+j), ctag, "b_addr", 32'(b_addr), 32'(k*16+j));
         end
         chk(c_we === exp_wr, "R5", "c_we", 32'(c_we), 32'(exp_wr));
         chk(c_ce === exp_wr, "R5", "c_ce", 32'(c_ce), 32'(exp_wr));
         if (exp_wr) begin
            int ad = (m / 256) * 16 + (m / 16) % 16;
            chk(c_addr === 8'(ad), "R5", "c_addr", 32'(c_addr), 32'(ad));
            chk(c_wdata === mc[ad], dtag, "c_wdata", c_wdata, mc[ad]);
         end
         chk(done === exp_end, "R7", "done", 32'(done), 32'(exp_end));
         chk(idle === exp_end, stag, "idle", 32'(idle), 32'(exp_end));
         chk(ready === exp_end, stag, "ready", 32'(ready), 32'(exp_end));
         start = poke && (cyc == 100 || cyc == 4099);  // R8: ignored pulses
         if (cyc == 4100) begin
            if (chain_next) begin
               fill(next_kind);
               start = 1'b1;                          // R10
            end
         end
         @(negedge clk);
      end
   endtask

   initial begin
      fill(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(idle === 1'b1,  "R1", "idle",  32'(idle), 32'd1);
      chk(ready === 1'b1, "R1", "ready", 32'(ready), 32'd1);
      chk(done === 1'b0,  "R1", "done",  32'(done), 32'd0);
      chk(a_ce === 1'b0 && b_ce === 1'b0, "R1", "read enables", 32'({a_ce, b_ce}), 32'd0);
      chk(c_ce === 1'b0 && c_we === 1'b0, "R1", "write enables", 32'({c_ce, c_we}), 32'd0);

      run_job(1'b0, 1'b1, 1'b0, 0, "R4");   // small mixed-sign data, pokes
      start = 1'b0;
      chk(idle === 1'b1 && done === 1'b0, "R7", "rest after job", 32'({idle, done}), 32'b10);
      fill(1);
      run_job(1'b0, 1'b0, 1'b1, 2, "R6");   // overflow data, then chain
      run_job(1'b1, 1'b0, 1'b0, 0, "R9");   // chained random job
      start = 1'b0;
      chk(idle === 1'b1 && done === 1'b0, "R7", "rest after chain", 32'({idle, done}), 32'b10);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule